// File: doc/BRIEF.md
# Disk Interface Task-File Register Block

This block is the device-side register file of a parallel disk interface, seen from the host bus. The host reads and writes registers by address in single-cycle accesses (`host_cs` high for one clock, `host_we` picks the direction). The block holds two address bytes and a mode byte. It also holds a command register and a status byte, which the host reads both as primary status and as alternate status. A 16-bit data port passes words between the host and an external buffer, one word per access.

A command write starts the device core through a one-cycle pulse that carries the command code. While the core works, the block reports busy. The core can open a transfer window, which raises DRQ, and close it again. When it signals completion, the block overwrites the address bytes with the core's current position and latches the result flags. Both the completion and the opening of a transfer window raise the host interrupt. A read of primary status clears that interrupt. A read of alternate status leaves it in place.

A three-state machine runs the sequencing. IDLE is reset, BSY=0 and DRQ=0. BUSY has BSY=1. XFER has DRQ=1 and BSY=0. The transitions are:
- IDLE to BUSY on a command write.
- BUSY to XFER on `core_drq_set`.
- XFER to BUSY on `core_drq_clr`, or on a command write.
- BUSY or XFER back to IDLE on `core_done`.

In BUSY and XFER, `core_done` takes priority over every other event. In IDLE, the core inputs are ignored.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset, status and alternate status read 0x40 (RDY only), both address bytes and the mode byte read 0, `host_irq` and `cmd_start` are 0.
- R2: Status is read at address 4 and alternate status at address 5. Both return the same byte, laid out from bit 7 down to bit 0 as BSY, RDY, DF, DSC, DRQ, COR, IDX, ERR. RDY is always 1.
- R3: A host read of address 4 deasserts `host_irq` from the next cycle, unless an interrupt event occurs in the same cycle. A read of address 5 leaves `host_irq` unchanged.
- R4: A write to address 4 while BSY=0 makes `cmd_start` high for exactly one cycle, the cycle after the write, with `cmd_code` equal to the written low byte. The same write enters BUSY, so BSY=1 from that cycle, and clears the latched result flags.
- R5: A write to address 4 while BSY=1 is ignored: no `cmd_start` pulse and no state change.
- R6: Address 1 (low address byte), address 2 (high address byte) and address 3 (mode byte) are writable and read back. They drive `cur_cyl_lo`, `cur_cyl_hi`, and `lba_mode`, which is mode bit 6.
- R7: `core_done` in BUSY or XFER loads `core_pos[7:0]` into the low byte and `core_pos[15:8]` into the high byte. It also returns to IDLE and raises `host_irq`. It latches `core_flags`, with bits 4..0 = DF, DSC, COR, IDX, ERR, into the status byte.
- R8: `core_drq_set` in BUSY enters XFER (DRQ=1, BSY=0) and raises `host_irq`. `core_drq_clr` in XFER returns to BUSY.
- R9: With DRQ=1, a read of address 0 returns `buf_rdata` and pulses `buf_pop` in the same cycle. When `core_ecc` is 1, the upper byte returned is 0.
- R10: With DRQ=1, a write of address 0 pulses `buf_push` with `buf_wdata` equal to `host_wdata`. When `core_ecc` is 1, the upper byte of `buf_wdata` is 0.
- R11: With DRQ=0, a read of address 0 returns 0 and a write of address 0 is ignored. Neither one pulses `buf_pop` or `buf_push`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host access in this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| host_irq | output | 1 | Interrupt to host |
| cmd_start | output | 1 | One-cycle command launch to core |
| cmd_code | output | 8 | Command code for the launch |
| cur_cyl_lo | output | 8 | Low address byte |
| cur_cyl_hi | output | 8 | High address byte |
| lba_mode | output | 1 | Linear addressing selected |
| core_done | input | 1 | Command completion |
| core_pos | input | 16 | Current position at completion |
| core_flags | input | 5 | Result flags DF, DSC, COR, IDX, ERR |
| core_drq_set | input | 1 | Open transfer window |
| core_drq_clr | input | 1 | Close transfer window |
| core_ecc | input | 1 | Byte-wide ECC transfer |
| buf_rdata | input | 16 | Word from buffer |
| buf_wdata | output | 16 | Word to buffer |
| buf_pop | output | 1 | Buffer read strobe |
| buf_push | output | 1 | Buffer write strobe |

## Verification
The assertions check these behaviours on every cycle:
- a launch pulse lasts one cycle and only follows a non-busy state;
- a write while busy never launches;
- a primary status read clears the interrupt, and an alternate read keeps it;
- the address writeback matches the completion position;
- the data port stays silent and zero while DRQ is low.

Only the bench's scenarios can show the rest: the exact status byte layout after each flag pattern, the read-back of every address byte value, and the ECC byte narrowing for reads and writes.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
    localparam int TF_ADDR_W = 3;
    localparam int TF_FLAG_W = 5;

    localparam logic [TF_ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [TF_ADDR_W-1:0] A_CYLL = 3'd1;
    localparam logic [TF_ADDR_W-1:0] A_CYLH = 3'd2;
    localparam logic [TF_ADDR_W-1:0] A_MODE = 3'd3;
    localparam logic [TF_ADDR_W-1:0] A_CMD  = 3'd4;
    localparam logic [TF_ADDR_W-1:0] A_ALT  = 3'd5;

    localparam int MODE_LBA_BIT = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_XFER = 2'd2
    } tf_state_e;
endpackage

// File: rtl/ata_tf_fsm.sv
module ata_tf_fsm
    import ata_tf_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [REG_W-1:0] cmd_wdata,
    input  logic             core_done,
    input  logic             core_drq_set,
    input  logic             core_drq_clr,
    output logic             bsy,
    output logic             drq,
    output logic             cmd_acc,
    output logic             done_acc,
    output logic             irq_evt,
    output logic             cmd_start,
    output logic [REG_W-1:0] cmd_code
);
    tf_state_e state_q, state_d;
    logic      drq_acc;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        cmd_acc  = 1'b0;
        done_acc = 1'b0;
        drq_acc  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr) begin
                    state_d = ST_BUSY;
                    cmd_acc = 1'b1;
                end
            end
            ST_BUSY: begin
                if (core_done) begin
                    state_d  = ST_IDLE;
                    done_acc = 1'b1;
                end else if (core_drq_set) begin
                    state_d = ST_XFER;
                    drq_acc = 1'b1;
                end
            end
            ST_XFER: begin
                if (core_done) begin
                    state_d  = ST_IDLE;
                    done_acc = 1'b1;
                end else if (cmd_wr) begin
                    state_d = ST_BUSY;
                    cmd_acc = 1'b1;
                end else if (core_drq_clr) begin
                    state_d = ST_BUSY;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign bsy     = (state_q == ST_BUSY);
    assign drq     = (state_q == ST_XFER);
    assign irq_evt = done_acc | drq_acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_start <= cmd_acc;
            if (cmd_acc) cmd_code <= cmd_wdata;
        end
    end

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);
    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> bsy);
    // R5
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy && cmd_wr) |=> !cmd_start);
endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic stat_rd,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (set_evt) irq <= 1'b1;
        else if (stat_rd) irq <= 1'b0;
    end

    // R3
    stat_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !set_evt) |=> !irq);
    // R7
    evt_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> irq);
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [TF_ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 cmd_acc,
    input  logic                 done_acc,
    input  logic [2*REG_W-1:0]   done_pos,
    input  logic [TF_FLAG_W-1:0] done_flags,
    output logic [REG_W-1:0]     cyl_lo,
    output logic [REG_W-1:0]     cyl_hi,
    output logic [REG_W-1:0]     mode,
    output logic [TF_FLAG_W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyl_lo <= '0;
            cyl_hi <= '0;
            mode   <= '0;
            flags  <= '0;
        end else begin
            if (done_acc) begin
                cyl_lo <= done_pos[REG_W-1:0];
                cyl_hi <= done_pos[2*REG_W-1:REG_W];
                flags  <= done_flags;
            end else begin
                if (cmd_acc) flags <= '0;
                if (wr_en && wr_addr == A_CYLL) cyl_lo <= wr_data;
                if (wr_en && wr_addr == A_CYLH) cyl_hi <= wr_data;
            end
            if (wr_en && wr_addr == A_MODE) mode <= wr_data;
        end
    end

    // R7
    writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_acc |=> ({cyl_hi, cyl_lo} == $past(done_pos)));
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int DATA_W = 2 * REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_cs,
    input  logic                 host_we,
    input  logic [TF_ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_irq,
    output logic                 cmd_start,
    output logic [REG_W-1:0]     cmd_code,
    output logic [REG_W-1:0]     cur_cyl_lo,
    output logic [REG_W-1:0]     cur_cyl_hi,
    output logic                 lba_mode,
    input  logic                 core_done,
    input  logic [2*REG_W-1:0]   core_pos,
    input  logic [TF_FLAG_W-1:0] core_flags,
    input  logic                 core_drq_set,
    input  logic                 core_drq_clr,
    input  logic                 core_ecc,
    input  logic [DATA_W-1:0]    buf_rdata,
    output logic [DATA_W-1:0]    buf_wdata,
    output logic                 buf_pop,
    output logic                 buf_push
);
    localparam int HI_W = DATA_W - REG_W;

    logic                 rd, wr, stat_rd, alt_rd, cmd_wr;
    logic                 bsy, drq, cmd_acc, done_acc, irq_evt;
    logic [REG_W-1:0]     mode;
    logic [TF_FLAG_W-1:0] flags;
    logic [REG_W-1:0]     status;
    logic [DATA_W-1:0]    data_word;

    assign rd      = host_cs & ~host_we;
    assign wr      = host_cs & host_we;
    assign stat_rd = rd & (host_addr == A_CMD);
    assign alt_rd  = rd & (host_addr == A_ALT);
    assign cmd_wr  = wr & (host_addr == A_CMD);

    ata_tf_fsm #(.REG_W(REG_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_wdata(host_wdata[REG_W-1:0]),
        .core_done(core_done), .core_drq_set(core_drq_set), .core_drq_clr(core_drq_clr),
        .bsy(bsy), .drq(drq), .cmd_acc(cmd_acc), .done_acc(done_acc), .irq_evt(irq_evt),
        .cmd_start(cmd_start), .cmd_code(cmd_code)
    );

    ata_tf_irq irq_i (
        .clk(clk), .rst_n(rst_n),
        .set_evt(irq_evt), .stat_rd(stat_rd), .irq(host_irq)
    );

    ata_tf_regs #(.REG_W(REG_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr), .wr_addr(host_addr), .wr_data(host_wdata[REG_W-1:0]),
        .cmd_acc(cmd_acc), .done_acc(done_acc),
        .done_pos(core_pos), .done_flags(core_flags),
        .cyl_lo(cur_cyl_lo), .cyl_hi(cur_cyl_hi), .mode(mode), .flags(flags)
    );

    assign lba_mode = mode[MODE_LBA_BIT];

    // Status byte: BSY RDY DF DSC DRQ COR IDX ERR (bit 7..0); flags = {DF,DSC,COR,IDX,ERR}
    assign status = {bsy, 1'b1, flags[4], flags[3], drq, flags[2], flags[1], flags[0]};

    assign data_word = core_ecc ? {{HI_W{1'b0}}, buf_rdata[REG_W-1:0]} : buf_rdata;
    assign buf_wdata = core_ecc ? {{HI_W{1'b0}}, host_wdata[REG_W-1:0]} : host_wdata;
    assign buf_pop   = rd & (host_addr == A_DATA) & drq;
    assign buf_push  = wr & (host_addr == A_DATA) & drq;

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_DATA:  host_rdata = drq ? data_word : '0;
            A_CYLL:  host_rdata = {{HI_W{1'b0}}, cur_cyl_lo};
            A_CYLH:  host_rdata = {{HI_W{1'b0}}, cur_cyl_hi};
            A_MODE:  host_rdata = {{HI_W{1'b0}}, mode};
            A_CMD:   host_rdata = {{HI_W{1'b0}}, status};
            A_ALT:   host_rdata = {{HI_W{1'b0}}, status};
            default: host_rdata = '0;
        endcase
    end

    // R3
    alt_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq && alt_rd) |=> host_irq);
    // R11
    data_idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && host_addr == A_DATA && !drq) |-> (host_rdata == '0 && !buf_pop));
    // R11
    data_idle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && host_addr == A_DATA && !drq) |-> !buf_push);
    // R2
    busy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bsy && drq));
endmodule

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_cs, host_we;
    logic [2:0]  host_addr;
    logic [15:0] host_wdata, host_rdata;
    logic        host_irq, cmd_start, lba_mode;
    logic [7:0]  cmd_code, cur_cyl_lo, cur_cyl_hi;
    logic        core_done, core_drq_set, core_drq_clr, core_ecc;
    logic [15:0] core_pos, buf_rdata, buf_wdata;
    logic [4:0]  core_flags;
    logic        buf_pop, buf_push;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile_regs dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
        .cmd_start(cmd_start), .cmd_code(cmd_code),
        .cur_cyl_lo(cur_cyl_lo), .cur_cyl_hi(cur_cyl_hi), .lba_mode(lba_mode),
        .core_done(core_done), .core_pos(core_pos), .core_flags(core_flags),
        .core_drq_set(core_drq_set), .core_drq_clr(core_drq_clr), .core_ecc(core_ecc),
        .buf_rdata(buf_rdata), .buf_wdata(buf_wdata),
        .buf_pop(buf_pop), .buf_push(buf_push)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one host access: inputs driven at negedge, outputs sampled 1 time unit later
    task automatic bus(input logic we, input logic [2:0] a, input logic [15:0] d,
                       output logic [15:0] rdat, output logic pop, output logic push,
                       output logic [15:0] wdat);
        @(negedge clk);
        host_cs = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        #1;
        rdat = host_rdata; pop = buf_pop; push = buf_push; wdat = buf_wdata;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        logic [15:0] r, w; logic p, q;
        bus(1'b1, a, d, r, p, q, w);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] r);
        logic [15:0] w; logic p, q;
        bus(1'b0, a, 16'h0, r, p, q, w);
    endtask

    task automatic pulse_done(input logic [15:0] pos, input logic [4:0] fl);
        @(negedge clk);
        core_done = 1'b1; core_pos = pos; core_flags = fl;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic pulse_drq(input logic set);
        @(negedge clk);
        if (set) core_drq_set = 1'b1; else core_drq_clr = 1'b1;
        @(negedge clk);
        core_drq_set = 1'b0; core_drq_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] r, w, exp;
        logic p, q;
        rst_n = 1'b0; host_cs = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        core_done = 1'b0; core_drq_set = 1'b0; core_drq_clr = 1'b0; core_ecc = 1'b0;
        core_pos = '0; core_flags = '0; buf_rdata = 16'hBEEF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd4, r); chk("R1 status", r, 16'h0040);
        rd(3'd5, r); chk("R1 alt status", r, 16'h0040);
        rd(3'd1, r); chk("R1 cyl lo", r, 16'h0);
        rd(3'd2, r); chk("R1 cyl hi", r, 16'h0);
        rd(3'd3, r); chk("R1 mode", r, 16'h0);
        chk("R1 irq", {15'h0, host_irq}, 16'h0);
        chk("R1 cmd_start", {15'h0, cmd_start}, 16'h0);

        // R11 data port idle
        bus(1'b0, 3'd0, 16'h0, r, p, q, w);
        chk("R11 idle read data", r, 16'h0);
        chk("R11 idle pop", {15'h0, p}, 16'h0);
        bus(1'b1, 3'd0, 16'h1234, r, p, q, w);
        chk("R11 idle push", {15'h0, q}, 16'h0);

        // R6 address byte sweep
        for (int v = 0; v < 256; v++) begin
            wr(3'd1, 16'(v));
            wr(3'd2, 16'(8'(255 - v)));
            rd(3'd1, r); chk("R6 cyl lo readback", r, 16'(v));
            rd(3'd2, r); chk("R6 cyl hi readback", r, 16'(255 - v));
            chk("R6 cyl outputs", {cur_cyl_hi, cur_cyl_lo}, {8'(255 - v), 8'(v)});
        end
        wr(3'd3, 16'h0040);
        rd(3'd3, r); chk("R6 mode readback", r, 16'h0040);
        chk("R6 lba_mode set", {15'h0, lba_mode}, 16'h1);
        wr(3'd3, 16'h00BF);
        chk("R6 lba_mode clear", {15'h0, lba_mode}, 16'h0);

        // R4 R5 R7 R2 R3 command cycles
        for (int i = 0; i < 32; i++) begin
            logic [7:0]  code;
            logic [15:0] pos;
            logic [4:0]  fl;
            code = 8'(i * 37 + 5);
            pos  = 16'(i * 4099 + 7);
            fl   = 5'(i);
            wr(3'd4, {8'h0, code});
            chk("R4 start pulse", {15'h0, cmd_start}, 16'h1);
            chk("R4 start code", {8'h0, cmd_code}, {8'h0, code});
            @(negedge clk);
            chk("R4 pulse one cycle", {15'h0, cmd_start}, 16'h0);
            rd(3'd4, r); chk("R2 busy status", r, 16'h00C0);
            wr(3'd4, {8'h0, ~code});
            chk("R5 busy write no pulse", {15'h0, cmd_start}, 16'h0);
            chk("R5 code kept", {8'h0, cmd_code}, {8'h0, code});
            pulse_done(pos, fl);
            chk("R7 cyl writeback", {cur_cyl_hi, cur_cyl_lo}, pos);
            chk("R7 irq raised", {15'h0, host_irq}, 16'h1);
            exp = {8'h0, 1'b0, 1'b1, fl[4], fl[3], 1'b0, fl[2], fl[1], fl[0]};
            rd(3'd5, r); chk("R2 alt status layout", r, exp);
            chk("R3 alt read keeps irq", {15'h0, host_irq}, 16'h1);
            rd(3'd4, r); chk("R2 status layout", r, exp);
            chk("R3 status read clears irq", {15'h0, host_irq}, 16'h0);
        end

        // R8 R9 R10 transfer window
        wr(3'd4, 16'h0020);
        pulse_drq(1'b1);
        chk("R8 drq irq", {15'h0, host_irq}, 16'h1);
        rd(3'd4, r); chk("R8 xfer status", r, 16'h0048);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] word;
            word = 16'(k * 16'h1357) ^ 16'hA55A;
            core_ecc = k[0];
            buf_rdata = word;
            bus(1'b0, 3'd0, 16'h0, r, p, q, w);
            chk("R9 data read", r, k[0] ? {8'h0, word[7:0]} : word);
            chk("R9 pop strobe", {15'h0, p}, 16'h1);
            bus(1'b1, 3'd0, ~word, r, p, q, w);
            chk("R10 push strobe", {15'h0, q}, 16'h1);
            chk("R10 push data", w, k[0] ? {8'h0, ~word[7:0]} : ~word);
        end
        core_ecc = 1'b0;
        pulse_drq(1'b0);
        rd(3'd4, r); chk("R8 drq clear back to busy", r, 16'h00C0);
        pulse_drq(1'b1);
        pulse_done(16'hCAFE, 5'h01);
        rd(3'd4, r); chk("R7 done from xfer status", r, 16'h0041);
        bus(1'b0, 3'd0, 16'h0, r, p, q, w);
        chk("R11 read after done", r, 16'h0);
        chk("R11 no pop after done", {15'h0, p}, 16'h0);
        chk("R7 cyl after xfer done", {cur_cyl_hi, cur_cyl_lo}, 16'hCAFE);

        finish_run();
    end
endmodule